// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets synchronous logic use an external asynchronous static RAM of 4096 four-bit words. The system side offers one read or one write at a time over a valid/ready handshake. The memory side drives the address, an active-low select and an active-low write strobe. The shared data bus is split into an output value, an output enable for the pad driver, and an input value taken from the pad.

Every analog timing limit of the RAM is a picosecond parameter. The clock period is a picosecond parameter too. Each limit is rounded up to whole clock cycles, and never to fewer than one cycle. An access walks through a fixed sequence of states: idle, address setup, strobe, hold and turnaround. Read data is registered and returned with a one-cycle response pulse. The turnaround state follows reads only. It lets the RAM release the bus before any later write drives it.

Top module: `asram_ctrl`

## Requirements
- R1: Out of reset, select and write strobe are high, the bus output enable is low, `rsp_valid` is low and `req_ready` is high.
- R2: A request is taken only when `req_ready` is high. `req_ready` stays low from the accepting edge until the access has fully finished. A `req_valid` pulse while `req_ready` is low has no effect on the memory contents.
- R3: A write holds select and write strobe low together for at least ceil(T_WP/CLK) cycles, and never for fewer than 1. The data on the bus at the end of that overlap is stored at the presented address.
- R4: The output enable is high only during a write. It is high for at least ceil(T_DW/CLK) cycles before the write overlap ends. It is never high while select is low and write strobe is high.
- R5: The output enable rises at least ceil(T_WHZ/CLK) cycles after the write strobe falls. It never rises on the same edge as the strobe.
- R6: The address never changes while select and write strobe are both low.
- R7: For a read, select stays low with write strobe high for ceil(T_AA/CLK) cycles. The bus is sampled on the last of those cycles. `rsp_valid` is high for exactly one cycle, observed ceil(T_AA/CLK)+2 clock edges after the accepting edge. Writes never raise `rsp_valid`.
- R8: After a read, at least ceil(T_CHZ/CLK) cycles pass from the rise of select to the next rise of the output enable.
- R9: After a write overlap ends, the output enable and the address are held for one more cycle, so the data hold time is positive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle pulse, read data valid |
| rsp_rdata | output | DATA_W | Registered read data |
| mem_addr | output | ADDR_W | RAM address lines |
| mem_cs_n | output | 1 | RAM select, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_dq_out | output | DATA_W | Value for the data pads |
| mem_dq_oe | output | 1 | Data pad driver enable |
| mem_dq_in | input | DATA_W | Value seen on the data pads |

## Verification
The bench uses a cycle-level RAM model with timing checks. Every location is written, then read back, and then read, rewritten and read again in alternation, so that a read is always followed by a write. The model returns inverted data until the access time has elapsed, so a controller that samples one cycle early returns wrong words. The model also flags four faults. The first is an address that moves under an active strobe. The second is a bus driven during a read or before the high-impedance window has passed. The third is data set up too briefly. The fourth is a write pulse that is too short. Any of these faults would corrupt the RAM or cause a bus fight. A request pulsed while the controller is busy must leave the stored word unchanged, and a read of that word afterwards shows this.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_TURN
  } asram_st_t;

  // Round a picosecond limit up to clock cycles, never below one.
  function automatic int ps_to_cyc(input int lim_ps, input int clk_ps);
    int c;
    c = (lim_ps + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  output logic [W-1:0] elapsed
);
  always_ff @(posedge clk) begin
    if (rst || clr) elapsed <= '0;
    else if (elapsed != {W{1'b1}}) elapsed <= elapsed + 1'b1;
  end
endmodule

// File: rtl/asram_req_reg.sv
module asram_req_reg #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_i,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic              wr_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
    end else if (load) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
      wr_q    <= wr_i;
    end
  end
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 4,
  parameter int CLK_PS    = 10000,
  parameter int T_AA_PS   = 15000,
  parameter int T_WP_PS   = 15000,
  parameter int T_DW_PS   = 9000,
  parameter int T_WHZ_PS  = 6000,
  parameter int T_CHZ_PS  = 8000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int ACC_CYC  = ps_to_cyc(T_AA_PS, CLK_PS);
  localparam int WP_CYC   = ps_to_cyc(T_WP_PS, CLK_PS);
  localparam int DS_CYC   = ps_to_cyc(T_DW_PS, CLK_PS);
  localparam int WHZ_CYC  = ps_to_cyc(T_WHZ_PS, CLK_PS);
  localparam int CHZ_CYC  = ps_to_cyc(T_CHZ_PS, CLK_PS);
  localparam int WSTB_CYC = imax(WP_CYC, WHZ_CYC + DS_CYC);
  localparam int TMR_W    = $clog2(imax(imax(ACC_CYC, WSTB_CYC), CHZ_CYC) + 1) + 1;

  asram_st_t          st;
  logic [TMR_W-1:0]   el;
  logic               tmr_clr;
  logic               take;
  logic               wr_q;

  assign take    = (st == ST_IDLE) && req_valid;
  assign tmr_clr = (st == ST_SETUP) || (st == ST_HOLD);

  asram_timer #(.W(TMR_W)) u_timer (
    .clk(clk), .rst(rst), .clr(tmr_clr), .elapsed(el)
  );

  asram_req_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
    .clk(clk), .rst(rst), .load(take),
    .addr_i(req_addr), .wdata_i(req_wdata), .wr_i(req_write),
    .addr_q(mem_addr), .wdata_q(mem_dq_out), .wr_q(wr_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      req_ready <= 1'b1;
      mem_cs_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (req_valid) begin
            st        <= ST_SETUP;
            req_ready <= 1'b0;
          end
        end
        ST_SETUP: begin
          st       <= ST_STROBE;
          mem_cs_n <= 1'b0;
          mem_we_n <= ~wr_q;
        end
        ST_STROBE: begin
          if (wr_q) begin
            if (int'(el) == WHZ_CYC - 1) mem_dq_oe <= 1'b1;
            if (int'(el) == WSTB_CYC - 1) begin
              mem_cs_n <= 1'b1;
              mem_we_n <= 1'b1;
              st       <= ST_HOLD;
            end
          end else if (int'(el) == ACC_CYC - 1) begin
            rsp_rdata <= mem_dq_in;
            rsp_valid <= 1'b1;
            mem_cs_n  <= 1'b1;
            st        <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          mem_dq_oe <= 1'b0;
          if (wr_q) begin
            st        <= ST_IDLE;
            req_ready <= 1'b1;
          end else begin
            st <= ST_TURN;
          end
        end
        ST_TURN: begin
          if (int'(el) == CHZ_CYC - 1) begin
            st        <= ST_IDLE;
            req_ready <= 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R2: ready only while idle with the RAM deselected
  assert_ready_idle_R2: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (st == ST_IDLE) && mem_cs_n);

  // R6: address frozen while both strobes are low
  assert_addr_stable_R6: assert property (@(posedge clk) disable iff (rst)
    (!mem_cs_n && !mem_we_n) |=> (mem_cs_n || mem_we_n || $stable(mem_addr)));

  // R4: never drive the pads while the RAM is reading
  assert_no_read_drive_R4: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> !(!mem_cs_n && mem_we_n));

  // R4: driver only in a write access
  assert_oe_write_only_R4: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> wr_q && ((st == ST_STROBE) || (st == ST_HOLD)));

  // R5: driver rises strictly after the write strobe fell
  assert_oe_after_we_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_dq_oe) |-> !mem_we_n && $past(!mem_we_n));

  // R7: response is a single-cycle pulse
  assert_rsp_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R9: driver still on in the cycle after the overlap ends
  assert_data_hold_R9: assert property (@(posedge clk) disable iff (rst)
    ($rose(mem_we_n) && $past(mem_dq_oe)) |-> mem_dq_oe);

endmodule

// File: tb/tb_asram_ctrl.sv
module tb_asram_ctrl;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int AW = 12, DW = 4, NW = 1 << AW;
  localparam int CLK_PS = 10000, T_AA = 15000, T_WP = 15000, T_DW = 9000;
  localparam int T_WHZ = 6000, T_CHZ = 8000;
  localparam int ACC_E = (T_AA + CLK_PS - 1) / CLK_PS;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, mem_cs_n, mem_we_n, mem_dq_oe;
  logic [DW-1:0] rsp_rdata, mem_dq_out, mem_dq_in;
  logic [AW-1:0] mem_addr;

  int errors = 0, checks = 0, cyc = 0;

  always #5ns clk = ~clk;

  asram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CLK_PS(CLK_PS), .T_AA_PS(T_AA),
    .T_WP_PS(T_WP), .T_DW_PS(T_DW), .T_WHZ_PS(T_WHZ), .T_CHZ_PS(T_CHZ)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      check(1'b0, "watchdog", cyc, 150000);
      finish_run();
    end
  end

  // ---- cycle-level RAM model with timing checks (sampled at negedge) ----
  logic [DW-1:0] ram [NW];
  logic rd_ok = 1'b0;
  bit prev_low = 1'b0, prev_oe = 1'b0, prev_rd = 1'b0;
  logic [AW-1:0] prev_addr = '0;
  logic [DW-1:0] prev_dq = '0;
  int low_n = 0, oe_n = 0, hi_n = 1000, rd_n = 0;

  assign mem_dq_in = rd_ok ? ram[mem_addr] : ~ram[mem_addr];

  always @(negedge clk) begin
    bit low, rd;
    if (!rst) begin
      low = !mem_cs_n && !mem_we_n;
      rd  = !mem_cs_n && mem_we_n;
      if (low) begin
        if (prev_low && mem_addr != prev_addr)
          check(1'b0, "R6 addr moved", int'(mem_addr), int'(prev_addr));
        low_n++;
        if (mem_dq_oe) begin
          oe_n++;
          if (!prev_oe) begin
            check((low_n - 1) * CLK_PS >= T_WHZ, "R5 oe too early", (low_n - 1) * CLK_PS, T_WHZ);
            check((hi_n + low_n - 1) * CLK_PS >= T_CHZ, "R8 turnaround", (hi_n + low_n - 1) * CLK_PS, T_CHZ);
          end
        end
      end
      if (mem_dq_oe && rd) check(1'b0, "R4 drive during read", 1, 0);
      if (prev_low && !low) begin
        check(low_n * CLK_PS >= T_WP, "R3 write pulse", low_n * CLK_PS, T_WP);
        check(oe_n * CLK_PS >= T_DW, "R4 data setup", oe_n * CLK_PS, T_DW);
        check(mem_dq_oe && mem_addr == prev_addr, "R9 hold", int'(mem_dq_oe), 1);
        if (prev_oe) ram[prev_addr] = prev_dq;
        low_n = 0;
        oe_n  = 0;
      end
      if (rd) begin
        rd_n = (prev_rd && mem_addr == prev_addr) ? rd_n + 1 : 1;
        hi_n = 0;
      end else begin
        rd_n = 0;
        if (mem_cs_n && hi_n < 1000) hi_n++;
      end
      rd_ok    <= (rd_n * CLK_PS >= T_AA);
      prev_low = low;
      prev_rd  = rd;
      prev_oe  = mem_dq_oe;
      prev_addr = mem_addr;
      prev_dq  = mem_dq_out;
    end
  end

  function automatic logic [DW-1:0] pat(input int a, input int salt);
    return DW'((a ^ (a >> 4) ^ (a >> 8) ^ salt) & 'hF);
  endfunction

  task automatic do_write(input int a, input logic [DW-1:0] d);
    bit saw = 1'b0;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(a); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready) begin
      if (rsp_valid) saw = 1'b1;
      @(negedge clk);
    end
    if (saw) check(1'b0, "R7 rsp on write", 1, 0);
  endtask

  task automatic do_read(input int a, output logic [DW-1:0] d, output int lat);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(a);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 50) begin @(negedge clk); lat++; end
    d = rsp_rdata;
    @(negedge clk);
    if (rsp_valid) check(1'b0, "R7 pulse width", 2, 1);
  endtask

  initial begin
    logic [DW-1:0] d;
    int lat;
    for (int i = 0; i < NW; i++) ram[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(mem_cs_n && mem_we_n, "R1 strobes", int'({mem_cs_n, mem_we_n}), 3);
    check(!mem_dq_oe, "R1 oe", int'(mem_dq_oe), 0);
    check(req_ready && !rsp_valid, "R1 ready/rsp", int'({req_ready, rsp_valid}), 2);

    // R3: fill every word
    for (int a = 0; a < NW; a++) do_write(a, pat(a, 0));
    // R7: read back every word with latency check
    for (int a = 0; a < NW; a++) begin
      do_read(a, d, lat);
      check(d == pat(a, 0), "R7 read data", int'(d), int'(pat(a, 0)));
      if (a % 64 == 0) check(lat == ACC_E + 2, "R7 latency", lat, ACC_E + 2);
    end
    // R8: read followed by write, then read back
    for (int a = 0; a < 256; a++) begin
      do_read(a * 16 + 3, d, lat);
      check(d == pat(a * 16 + 3, 0), "R8 read", int'(d), int'(pat(a * 16 + 3, 0)));
      do_write(a * 16 + 3, pat(a, 5));
      do_read(a * 16 + 3, d, lat);
      check(d == pat(a, 5), "R3 rewrite", int'(d), int'(pat(a, 5)));
    end
    // R2: request pulsed while busy is ignored
    do_write(7, 4'h3);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(7);
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R2 ready low while busy", int'(req_ready), 0);
    req_valid = 1'b1; req_write = 1'b1; req_wdata = 4'hC;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    check(rsp_rdata == 4'h3, "R2 busy read", int'(rsp_rdata), 3);
    do_read(7, d, lat);
    check(d == 4'h3, "R2 ignored write", int'(d), 3);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule